// File: doc/BRIEF.md
# Four-Wire Serial Display Command Receiver

This block is the slave end of a four-wire synchronous serial link into a display controller. A host drives an active-low select, a serial clock, a serial data line and a line that marks each byte as a command or as data. The block brings these four lines into its own system clock domain and shifts one bit in on each rising serial clock edge, most significant bit first. Each completed byte appears on a parallel output, tagged command or data, together with a strobe that lasts one system clock. While select stays low, bytes follow one another with no gap. If select rises in the middle of a byte, or the asynchronous reset is pulsed, the partial byte is thrown away.

One command byte, set by a parameter, starts a read-back. During the next eight serial clocks the block drives a status byte onto a serial output, most significant bit first, and ignores the data input. The status byte is taken from an input port when the read starts. The output enable is low at all other times, so the output pad can be tied to the data input wire and a single line can carry both directions.

Top module: `spi4_cmd_rx`

## Requirements
- R1: Bits are taken from `sdin` on each rising `sclk` edge while `cs_n` is low, first bit into bit 7. After the eighth edge, `rx_byte` holds the eight bits in the order they arrived.
- R2: `rx_is_data` is the level of `dc` at the eighth rising edge of the byte: 1 means data and 0 means command. The level of `dc` during the first seven edges has no effect.
- R3: `rx_valid` is high for exactly one system clock cycle for each completed byte and never stays high for two cycles in a row.
- R4: While `cs_n` stays low, the rising edge after a byte's eighth edge is bit 7 of the next byte, and every byte in the run is delivered.
- R5: `cs_n` high clears the bit position. A byte cut short by `cs_n` rising produces no `rx_valid`, and the next byte starts at bit 7.
- R6: While `rst_n` is low, `rx_byte` is 0, `rx_valid` is 0 and `sdo_en` is 0. A partial byte in progress at reset is never delivered.
- R7: If `cs_n` is already low when `rst_n` is released, the next eight rising edges form a complete byte.
- R8: `sdo_en` is 0 while idle, while `cs_n` is high and while bytes are being written.
- R9: After a command byte (`dc`=0) equal to `RD_OPCODE` (default 8'hD8), `sdo_en` is 1 and `sdo` presents the `status_in` value sampled at that byte's completion, MSB first. Each bit is stable before the next rising edge and moves on after it. After eight edges `sdo_en` returns to 0.
- R10: During the eight read-back edges `sdin` is ignored and no `rx_valid` is produced. The edge after the read-back is bit 7 of a new written byte.
- R11: `RD_OPCODE` sent as data (`dc`=1) is delivered as a normal byte and starts no read-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdin | input | 1 | Serial data from the host |
| dc | input | 1 | Byte tag: 1 data, 0 command |
| status_in | input | 8 | Byte returned by a read-back |
| rx_byte | output | 8 | Last completed byte |
| rx_is_data | output | 1 | Tag of the last completed byte |
| rx_valid | output | 1 | One-cycle strobe for a completed byte |
| sdo | output | 1 | Read-back serial data |
| sdo_en | output | 1 | Drive enable for `sdo`; when low the pad is high impedance |

## Verification
The assertions assume that the serial lines change slowly compared with the system clock: each `sclk` level lasts at least four system clocks, and `sclk` is low whenever `rst_n` is released, so that no edge is invented at reset. They also assume that `dc` and `sdin` are stable around each rising edge. The bench holds each `sclk` phase for five system clocks and changes data and tag lines only while `sclk` is low, at times that are not on a system clock edge. Reset is applied and released only with `sclk` low.

// File: rtl/spi4rx_pkg.sv
package spi4rx_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef struct packed {
    logic [BYTE_W-1:0] value;
    logic              is_data;
  } rx_item_t;

  function automatic logic [BYTE_W-1:0] shift_msb_first(
    input logic [BYTE_W-1:0] cur, input logic bit_in);
    return {cur[BYTE_W-2:0], bit_in};
  endfunction

  function automatic logic is_last_pos(input logic [CNT_W-1:0] pos);
    return pos == CNT_W'(BYTE_W - 1);
  endfunction

  function automatic logic is_readback_cmd(
    input rx_item_t item, input logic [BYTE_W-1:0] opcode);
    return (!item.is_data) && (item.value == opcode);
  endfunction
endpackage

// File: rtl/spi4rx_sync.sv
module spi4rx_sync #(
  parameter int WIDTH   = 4,
  parameter int STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi4rx_framer.sv
module spi4rx_framer
  import spi4rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_high,
  input  logic              sclk_s,
  input  logic              sdin_s,
  input  logic              dc_s,
  input  logic              hold,
  output logic              sclk_rise,
  output logic              byte_done,
  output rx_item_t          done_item,
  output logic [CNT_W-1:0]  bit_pos,
  output rx_item_t          out_item,
  output logic              out_valid
);
  logic              sclk_d;
  logic [BYTE_W-1:0] shreg;

  assign sclk_rise = sclk_s && !sclk_d;
  assign byte_done = sclk_rise && !cs_high && !hold && is_last_pos(bit_pos);
  assign done_item.value   = shift_msb_first(shreg, sdin_s);
  assign done_item.is_data = dc_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_pos <= '0;
    end else if (cs_high) begin
      shreg   <= '0;
      bit_pos <= '0;
    end else if (sclk_rise && !hold) begin
      shreg   <= shift_msb_first(shreg, sdin_s);
      bit_pos <= bit_pos + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_item  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= byte_done;
      if (byte_done) out_item <= done_item;
    end
  end
endmodule

// File: rtl/spi4rx_readback.sv
module spi4rx_readback
  import spi4rx_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RD_OPCODE = 8'hD8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_high,
  input  logic              sclk_rise,
  input  logic              byte_done,
  input  rx_item_t          done_item,
  input  logic [BYTE_W-1:0] status_in,
  output logic              rd_start,
  output logic              rd_active,
  output logic              sdo,
  output logic              sdo_en
);
  logic [BYTE_W-1:0] out_sh;
  logic [CNT_W-1:0]  rd_pos;

  assign rd_start = byte_done && !rd_active && is_readback_cmd(done_item, RD_OPCODE);
  assign sdo      = out_sh[BYTE_W-1];
  assign sdo_en   = rd_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_active <= 1'b0;
      out_sh    <= '0;
      rd_pos    <= '0;
    end else if (cs_high) begin
      rd_active <= 1'b0;
      out_sh    <= '0;
      rd_pos    <= '0;
    end else if (rd_start) begin
      rd_active <= 1'b1;
      out_sh    <= status_in;
      rd_pos    <= '0;
    end else if (rd_active && sclk_rise) begin
      out_sh <= shift_msb_first(out_sh, 1'b0);
      rd_pos <= rd_pos + CNT_W'(1);
      if (is_last_pos(rd_pos)) rd_active <= 1'b0;
    end
  end
endmodule

// File: rtl/spi4_cmd_rx.sv
module spi4_cmd_rx
  import spi4rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] RD_OPCODE = 8'hD8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              dc,
  input  logic [BYTE_W-1:0] status_in,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_is_data,
  output logic              rx_valid,
  output logic              sdo,
  output logic              sdo_en
);
  localparam int NLINES = 4;
  localparam logic [NLINES-1:0] LINE_RST = 4'b1000;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] sync_lines;
  logic              w_cs_high;
  logic              w_sclk_s;
  logic              w_sdin_s;
  logic              w_dc_s;
  logic              w_sclk_rise;
  logic              w_byte_done;
  logic              w_rd_start;
  logic              w_rd_active;
  logic [CNT_W-1:0]  w_bit_pos;
  rx_item_t          w_done_item;
  rx_item_t          w_out_item;

  assign raw_lines = {cs_n, sclk, sdin, dc};
  assign {w_cs_high, w_sclk_s, w_sdin_s, w_dc_s} = sync_lines;

  spi4rx_sync #(
    .WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(LINE_RST)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(sync_lines)
  );

  spi4rx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .cs_high(w_cs_high),
    .sclk_s(w_sclk_s), .sdin_s(w_sdin_s), .dc_s(w_dc_s),
    .hold(w_rd_active), .sclk_rise(w_sclk_rise),
    .byte_done(w_byte_done), .done_item(w_done_item),
    .bit_pos(w_bit_pos), .out_item(w_out_item), .out_valid(rx_valid)
  );

  spi4rx_readback #(.RD_OPCODE(RD_OPCODE)) u_readback (
    .clk(clk), .rst_n(rst_n), .cs_high(w_cs_high),
    .sclk_rise(w_sclk_rise), .byte_done(w_byte_done),
    .done_item(w_done_item), .status_in(status_in),
    .rd_start(w_rd_start), .rd_active(w_rd_active),
    .sdo(sdo), .sdo_en(sdo_en)
  );

  assign rx_byte    = w_out_item.value;
  assign rx_is_data = w_out_item.is_data;
endmodule

// File: rtl/spi4_cmd_rx_chk.sv
module spi4_cmd_rx_chk
  import spi4rx_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RD_OPCODE = 8'hD8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_is_data,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              sdo_en,
  input logic              cs_high,
  input logic              sclk_rise,
  input logic              rd_start,
  input logic              rd_active,
  input logic [CNT_W-1:0]  bit_pos
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R3

  AST_VALID_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(sclk_rise)); // R1

  AST_CS_CLEARS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> bit_pos == '0); // R5

  AST_NO_DRIVE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> !sdo_en); // R8

  AST_READ_NEEDS_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> (rx_valid && !rx_is_data && rx_byte == RD_OPCODE)); // R11

  AST_READ_STARTS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> sdo_en); // R9

  AST_NO_VALID_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_active) && rd_active) |-> !rx_valid); // R10
endmodule

bind spi4_cmd_rx spi4_cmd_rx_chk #(.RD_OPCODE(RD_OPCODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_is_data(rx_is_data),
  .rx_byte(rx_byte), .sdo_en(sdo_en), .cs_high(w_cs_high),
  .sclk_rise(w_sclk_rise), .rd_start(w_rd_start), .rd_active(w_rd_active),
  .bit_pos(w_bit_pos)
);

// File: tb/spi4_cmd_rx_bench.sv
`timescale 1ns/1ps
module spi4_cmd_rx_bench;
  localparam logic [7:0] OPC = 8'hD8;
  localparam int HALF = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdin = 1'b0;
  logic dc = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic [7:0] rx_byte;
  logic rx_is_data, rx_valid, sdo, sdo_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [8:0] expq [$];

  always #5 clk = ~clk;

  spi4_cmd_rx u_spi4_cmd_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .dc(dc), .status_in(status_in), .rx_byte(rx_byte),
    .rx_is_data(rx_is_data), .rx_valid(rx_valid), .sdo(sdo), .sdo_en(sdo_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one serial clock cycle: data set while sclk low, then a rising edge
  task automatic pulse(input logic b, input logic d);
    sdin = b; dc = d;
    #HALF sclk = 1'b1;
    #HALF sclk = 1'b0;
  endtask

  // write one byte; dc_early is driven on the first seven bits, dc_last on the eighth
  task automatic send_byte(input logic [7:0] v, input logic dc_last, input logic dc_early,
                           input bit expect_out);
    if (expect_out) expq.push_back({dc_last, v});
    for (int i = 7; i >= 0; i--) begin
      check(sdo_en == 1'b0, "R8", sdo_en, 0);
      pulse(v[i], (i == 0) ? dc_last : dc_early);
    end
  endtask

  task automatic read_back(input logic [7:0] expv, input logic [7:0] change_to);
    #HALF;
    status_in = change_to;
    for (int i = 7; i >= 0; i--) begin
      check(sdo_en == 1'b1, "R9 enable", sdo_en, 1);
      check(sdo == expv[i], "R9 bit", sdo, expv[i]);
      pulse(~expv[i], 1'b1);
    end
    #HALF;
    check(sdo_en == 1'b0, "R9 release", sdo_en, 0);
  endtask

  // scoreboard monitor
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        check(!prev_valid, "R3", prev_valid, 0);
        if (expq.size() == 0) begin
          check(1'b0, "R10 unexpected byte", {rx_is_data, rx_byte}, 0);
        end else begin
          logic [8:0] e;
          e = expq.pop_front();
          check({rx_is_data, rx_byte} == e, "R1 R2 R4 byte", {rx_is_data, rx_byte}, e);
        end
      end
      prev_valid = rx_valid;
    end else begin
      prev_valid = 1'b0;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100;
    check(rx_byte == 8'h00 && rx_valid == 1'b0 && sdo_en == 1'b0, "R6 reset", rx_byte, 0);
    rst_n = 1'b1;
    #100;
    cs_n = 1'b0;
    #100;
    // R1 R2: single bytes, dc level on early bits irrelevant
    send_byte(8'hA6, 1'b0, 1'b1, 1'b1);
    send_byte(8'h3C, 1'b1, 1'b0, 1'b1);
    // R4: back-to-back run
    send_byte(8'h01, 1'b1, 1'b1, 1'b1);
    send_byte(8'h80, 1'b0, 1'b0, 1'b1);
    send_byte(8'hFF, 1'b1, 1'b0, 1'b1);
    send_byte(8'h00, 1'b0, 1'b1, 1'b1);
    #200;
    check(expq.size() == 0, "R4 delivered", expq.size(), 0);
    // R5: byte cut short by cs rising
    pulse(1'b1, 1'b0); pulse(1'b0, 1'b0); pulse(1'b1, 1'b0);
    cs_n = 1'b1;
    #200;
    check(sdo_en == 1'b0, "R8 deselected", sdo_en, 0);
    cs_n = 1'b0;
    #100;
    send_byte(8'h5A, 1'b1, 1'b1, 1'b1);
    #200;
    check(expq.size() == 0, "R5 fresh byte", expq.size(), 0);
    // R9 R10: read-back, status changed during read must not matter
    status_in = 8'hA5;
    send_byte(OPC, 1'b0, 1'b1, 1'b1);
    read_back(8'hA5, 8'h0F);
    send_byte(8'h96, 1'b1, 1'b1, 1'b1);
    #200;
    check(expq.size() == 0, "R10 after read", expq.size(), 0);
    // R11: opcode as data starts nothing
    status_in = 8'hFF;
    send_byte(OPC, 1'b1, 1'b0, 1'b1);
    send_byte(8'h00, 1'b1, 1'b1, 1'b1);
    #200;
    check(expq.size() == 0 && sdo_en == 1'b0, "R11 no read", sdo_en, 0);
    // second read-back with another status
    status_in = 8'h3C;
    send_byte(OPC, 1'b0, 1'b0, 1'b1);
    read_back(8'h3C, 8'hC3);
    // R6 R7: reset in middle of a byte with cs held low
    pulse(1'b1, 1'b1); pulse(1'b1, 1'b1); pulse(1'b0, 1'b1);
    rst_n = 1'b0;
    #40;
    check(rx_byte == 8'h00 && rx_valid == 1'b0 && sdo_en == 1'b0, "R6 abort", rx_byte, 0);
    #60;
    rst_n = 1'b1;
    #100;
    send_byte(8'hC7, 1'b1, 1'b0, 1'b1);
    #200;
    check(expq.size() == 0, "R7 ready after reset", expq.size(), 0);
    check(rx_byte == 8'hC7, "R7 value", rx_byte, 8'hC7);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule